// File: doc/BRIEF.md
# Handshake Command/Response Byte Framer

This block is the device-side framing engine of a byte-serial link. The host moves one active-low request line and the block answers on one active-low acknowledge line. Each completed strobe passes one byte through a shared shift-register byte. A transaction starts with a command byte. Argument bytes follow, and the framer then returns response bytes to the host. The number of argument bytes and the number of response bytes each come from a fixed per-command shape table. When the table marks a length as in-band, that length travels as a leading byte instead.

Once all arguments are in, the framer hands the command to an external executor. It holds a dispatch request until the executor signals completion. While it waits, the acknowledge line stays low, so the host cannot advance. The executor reads the arguments through a read port and leaves its reply in a response buffer through a write port. Commands that are not in the table are never dispatched. The framer answers them with zero bytes by itself.

Top module: `hs_cmd_framer`

## Requirements
- R1: After reset `ack_n` is 1, `sr_irq` is 0, `disp_valid` is 0 and the framer waits for a command byte.
- R2: A change of the pair {`host_req_n`,`ack_n`} into {0,1} is a byte strobe. One clock later `ack_n` is 0. If the direction is correct, `sr_irq` is high for exactly that one cycle.
- R3: A change of the pair into {1,0} is an acknowledge release. One clock later `ack_n` is 1, no byte is handled and `sr_irq` stays 0.
- R4: While the pair does not change, nothing happens, whatever `sr_in` and `host_wr` do. The pairs {1,1} and {0,0} are recorded but cause no action.
- R5: In the waiting state, a strobed byte becomes the command. The shape table gives the argument count and response length for each command code: 0x10 takes 0 arguments and returns 1 byte. 0x20 takes 1 and returns 0. 0x21 takes an in-band count and returns an in-band size. 0x30 takes 4 and returns 0. 0x38 takes 0 and returns 4. 0x40 takes an in-band count and returns 2. 0x50 takes 2 and returns an in-band size.
- R6: When the argument count is in-band, the first byte after the command is the count. A count of 0 completes the argument phase at once.
- R7: Argument bytes are stored in order at positions 0 to BUF_DEPTH-1 and can be read through `arg_rd_idx`/`arg_rd_data`. Bytes beyond BUF_DEPTH are dropped but still counted.
- R8: Command and argument bytes need `host_wr`=1, and response bytes need `host_wr`=0. On a strobe with the wrong direction, `ack_n` still falls, but `sr_irq` stays 0 and the byte and the state are left untouched.
- R9: For a table command, once the argument count is reached, `disp_valid` stays high with steady `disp_cmd` and `disp_argc` (the full argument count) until `exec_done`. During that time `ack_n` does not change.
- R10: A fixed response length N returns response-buffer bytes 0 to N-1 in order on host read strobes. The framer then waits for a new command.
- R11: An in-band response first returns the size that `exec_rsp_len` gave at `exec_done`, then that many buffer bytes. A size of 0 ends the transaction after the size byte.
- R12: A code outside the table is not dispatched. If bit 7 is 1, it takes 0 arguments and returns 3 zero bytes. Otherwise it takes 0 arguments and returns an in-band size of 0.
- R13: A table command with a fixed response length of 0 goes back to waiting for a command right after `exec_done`, and the pending acknowledge release is then served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_req_n | input | 1 | Host request line, active low |
| ack_n | output | 1 | Block acknowledge line, active low |
| host_wr | input | 1 | Shift-register direction: 1 means the host is writing |
| sr_in | input | 8 | Byte written by the host |
| sr_out | output | 8 | Byte presented to the host |
| sr_irq | output | 1 | One-cycle shift-register interrupt pulse |
| disp_valid | output | 1 | Dispatch request to the executor |
| disp_cmd | output | 8 | Command code being dispatched |
| disp_argc | output | 8 | Argument count of the dispatched command |
| arg_rd_idx | input | AW | Argument buffer read index |
| arg_rd_data | output | 8 | Argument buffer read data |
| exec_done | input | 1 | Executor completion pulse |
| exec_rsp_len | input | 8 | Response size from the executor, used when the size is in-band |
| rsp_wr_en | input | 1 | Response buffer write enable |
| rsp_wr_idx | input | AW | Response buffer write index |
| rsp_wr_data | input | 8 | Response buffer write data |

## Verification
The host's acknowledge release and the executor's completion can meet. After the last argument byte, the host raises its request while the dispatch is still open, so the release stays pending in the very cycle `exec_done` arrives. The executor model makes its last response-buffer write in the cycle right before that completion. The bench judges the result by the acknowledge line: it must stay low for the whole dispatch and rise only once the framer has left the dispatch wait. The bench then checks that the first byte the host reads back matches the final buffer write.

// File: rtl/hsf_pkg.sv
package hsf_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CMD  = 2'd1,
    ST_WAIT = 2'd2,
    ST_RSP  = 2'd3
  } hsf_state_e;

  typedef enum logic [1:0] {
    HS_NONE    = 2'd0,
    HS_STROBE  = 2'd1,
    HS_RELEASE = 2'd2,
    HS_OTHER   = 2'd3
  } hs_evt_e;

  typedef struct packed {
    logic       known;
    logic       arg_var;
    logic [7:0] arg_len;
    logic       rsp_var;
    logic [7:0] rsp_len;
  } cmd_shape_t;

  // Pair is {request_n, acknowledge_n}; only a change is an event.
  function automatic hs_evt_e hs_classify(input logic [1:0] pair, input logic [1:0] last);
    if (pair == last)       return HS_NONE;
    else if (pair == 2'b01) return HS_STROBE;
    else if (pair == 2'b10) return HS_RELEASE;
    else                    return HS_OTHER;
  endfunction

  function automatic cmd_shape_t mk_shape(input logic kn, input logic av, input logic [7:0] al,
                                          input logic rv, input logic [7:0] rl);
    cmd_shape_t s;
    s.known = kn; s.arg_var = av; s.arg_len = al; s.rsp_var = rv; s.rsp_len = rl;
    return s;
  endfunction

  function automatic cmd_shape_t cmd_shape(input logic [7:0] c);
    case (c)
      8'h10:   return mk_shape(1'b1, 1'b0, 8'd0, 1'b0, 8'd1);
      8'h20:   return mk_shape(1'b1, 1'b0, 8'd1, 1'b0, 8'd0);
      8'h21:   return mk_shape(1'b1, 1'b1, 8'd0, 1'b1, 8'd0);
      8'h30:   return mk_shape(1'b1, 1'b0, 8'd4, 1'b0, 8'd0);
      8'h38:   return mk_shape(1'b1, 1'b0, 8'd0, 1'b0, 8'd4);
      8'h40:   return mk_shape(1'b1, 1'b1, 8'd0, 1'b0, 8'd2);
      8'h50:   return mk_shape(1'b1, 1'b0, 8'd2, 1'b1, 8'd0);
      default: return c[7] ? mk_shape(1'b0, 1'b0, 8'd0, 1'b0, 8'd3)
                           : mk_shape(1'b0, 1'b0, 8'd0, 1'b1, 8'd0);
    endcase
  endfunction

endpackage

// File: rtl/hsf_handshake.sv
module hsf_handshake
  import hsf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_n,
  input  logic hold,
  output logic ack_n,
  output logic ev_strobe,
  output logic ev_release
);

  logic [1:0] last_q;
  logic [1:0] pair;
  hs_evt_e    evt;

  assign pair       = {req_n, ack_n};
  assign evt        = hold ? HS_NONE : hs_classify(pair, last_q);
  assign ev_strobe  = (evt == HS_STROBE);
  assign ev_release = (evt == HS_RELEASE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_n  <= 1'b1;
      last_q <= 2'b11;
    end else begin
      case (evt)
        HS_RELEASE: begin ack_n <= 1'b1; last_q <= 2'b11; end
        HS_STROBE:  begin ack_n <= 1'b0; last_q <= 2'b00; end
        HS_OTHER:   last_q <= pair;
        default:    ;
      endcase
    end
  end

endmodule

// File: rtl/hsf_byte_store.sv
module hsf_byte_store #(
  parameter int DEPTH = 32,
  parameter int AW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_idx,
  output logic [7:0]    rd_data
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
    end else if (wr_en) begin
      mem[wr_idx] <= wr_data;
    end
  end

  assign rd_data = mem[rd_idx];

endmodule

// File: rtl/hs_cmd_framer.sv
module hs_cmd_framer
  import hsf_pkg::*;
#(
  parameter  int BUF_DEPTH = 32,
  localparam int AW        = $clog2(BUF_DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_req_n,
  output logic          ack_n,
  input  logic          host_wr,
  input  logic [7:0]    sr_in,
  output logic [7:0]    sr_out,
  output logic          sr_irq,
  output logic          disp_valid,
  output logic [7:0]    disp_cmd,
  output logic [7:0]    disp_argc,
  input  logic [AW-1:0] arg_rd_idx,
  output logic [7:0]    arg_rd_data,
  input  logic          exec_done,
  input  logic [7:0]    exec_rsp_len,
  input  logic          rsp_wr_en,
  input  logic [AW-1:0] rsp_wr_idx,
  input  logic [7:0]    rsp_wr_data
);

  hsf_state_e st_q, st_d;
  logic [7:0] cmd_q, cmd_d, arg_len_q, arg_len_d, arg_cnt_q, arg_cnt_d;
  logic [7:0] rsp_len_q, rsp_len_d, rsp_size_q, rsp_size_d, rsp_cnt_q, rsp_cnt_d;
  logic       known_q, known_d, arg_need_q, arg_need_d, rsp_var_q, rsp_var_d;
  logic [7:0] sr_out_q, sr_out_d;
  logic       irq_q, irq_d;

  // Named internal events, also observed by the bound checker
  logic       ev_strobe, ev_release, hs_hold, dir_ok, take_byte, arg_we;
  logic       args_fin, fin_known, fin_var;
  logic [7:0] fin_len, rsp_rd_data;
  cmd_shape_t shp;

  assign hs_hold   = (st_q == ST_WAIT);
  assign dir_ok    = (st_q == ST_RSP) ? !host_wr : host_wr;
  assign take_byte = ev_strobe && dir_ok;
  assign shp       = cmd_shape(sr_in);
  assign arg_we    = take_byte && (st_q == ST_CMD) && !arg_need_q && (int'(arg_cnt_q) < BUF_DEPTH);

  hsf_handshake u_hs (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_n      (host_req_n),
    .hold       (hs_hold),
    .ack_n      (ack_n),
    .ev_strobe  (ev_strobe),
    .ev_release (ev_release)
  );

  hsf_byte_store #(.DEPTH(BUF_DEPTH), .AW(AW)) u_arg_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (arg_we),
    .wr_idx  (arg_cnt_q[AW-1:0]),
    .wr_data (sr_in),
    .rd_idx  (arg_rd_idx),
    .rd_data (arg_rd_data)
  );

  hsf_byte_store #(.DEPTH(BUF_DEPTH), .AW(AW)) u_rsp_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (rsp_wr_en),
    .wr_idx  (rsp_wr_idx),
    .wr_data (rsp_wr_data),
    .rd_idx  (rsp_cnt_q[AW-1:0]),
    .rd_data (rsp_rd_data)
  );

  assign fin_known = (st_q == ST_IDLE) ? shp.known   : known_q;
  assign fin_var   = (st_q == ST_IDLE) ? shp.rsp_var : rsp_var_q;
  assign fin_len   = (st_q == ST_IDLE) ? shp.rsp_len : rsp_len_q;

  always_comb begin
    st_d       = st_q;      cmd_d     = cmd_q;     known_d   = known_q;
    arg_len_d  = arg_len_q; arg_cnt_d = arg_cnt_q; arg_need_d = arg_need_q;
    rsp_len_d  = rsp_len_q; rsp_cnt_d = rsp_cnt_q; rsp_var_d = rsp_var_q;
    rsp_size_d = rsp_size_q; sr_out_d = sr_out_q;
    irq_d      = 1'b0;
    args_fin   = 1'b0;
    if (st_q == ST_WAIT) begin
      if (exec_done) begin
        rsp_size_d = exec_rsp_len;
        st_d = (!rsp_var_q && rsp_len_q == 8'd0) ? ST_IDLE : ST_RSP;
      end
    end else if (take_byte) begin
      irq_d = 1'b1;
      case (st_q)
        ST_IDLE: begin
          cmd_d      = sr_in;        known_d   = shp.known;
          arg_len_d  = shp.arg_len;  arg_need_d = shp.arg_var;
          rsp_len_d  = shp.rsp_len;  rsp_var_d = shp.rsp_var;
          rsp_size_d = 8'd0;         arg_cnt_d = 8'd0;  rsp_cnt_d = 8'd0;
          st_d       = ST_CMD;
          args_fin   = !shp.arg_var && (shp.arg_len == 8'd0);
        end
        ST_CMD: begin
          if (arg_need_q) begin
            arg_len_d  = sr_in;
            arg_need_d = 1'b0;
            args_fin   = (sr_in == 8'd0);
          end else begin
            arg_cnt_d = arg_cnt_q + 8'd1;
            args_fin  = (arg_cnt_d == arg_len_q);
          end
        end
        ST_RSP: begin
          if (rsp_var_q) begin
            sr_out_d  = rsp_size_q;
            rsp_len_d = rsp_size_q;
            rsp_var_d = 1'b0;
            if (rsp_size_q == 8'd0) st_d = ST_IDLE;
          end else begin
            sr_out_d  = (known_q && int'(rsp_cnt_q) < BUF_DEPTH) ? rsp_rd_data : 8'h00;
            rsp_cnt_d = rsp_cnt_q + 8'd1;
            if (rsp_cnt_d == rsp_len_q) st_d = ST_IDLE;
          end
        end
        default: ;
      endcase
      if (args_fin) begin
        if (fin_known)                        st_d = ST_WAIT;
        else if (!fin_var && fin_len == 8'd0) st_d = ST_IDLE;
        else                                  st_d = ST_RSP;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE; cmd_q     <= 8'h00; known_q    <= 1'b0;
      arg_len_q  <= 8'd0;    arg_cnt_q <= 8'd0;  arg_need_q <= 1'b0;
      rsp_len_q  <= 8'd0;    rsp_cnt_q <= 8'd0;  rsp_var_q  <= 1'b0;
      rsp_size_q <= 8'd0;    sr_out_q  <= 8'h00; irq_q      <= 1'b0;
    end else begin
      st_q       <= st_d;       cmd_q     <= cmd_d;     known_q    <= known_d;
      arg_len_q  <= arg_len_d;  arg_cnt_q <= arg_cnt_d; arg_need_q <= arg_need_d;
      rsp_len_q  <= rsp_len_d;  rsp_cnt_q <= rsp_cnt_d; rsp_var_q  <= rsp_var_d;
      rsp_size_q <= rsp_size_d; sr_out_q  <= sr_out_d;  irq_q      <= irq_d;
    end
  end

  assign sr_out     = sr_out_q;
  assign sr_irq     = irq_q;
  assign disp_valid = (st_q == ST_WAIT);
  assign disp_cmd   = cmd_q;
  assign disp_argc  = arg_len_q;

endmodule

// File: rtl/hsf_chk.sv
module hsf_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ack_n,
  input logic       sr_irq,
  input logic       disp_valid,
  input logic [7:0] disp_cmd,
  input logic       exec_done,
  input logic       ev_strobe,
  input logic       ev_release
);

  // R2
  strobe_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_strobe |=> !ack_n);

  // R2
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sr_irq |=> !sr_irq);

  // R2
  irq_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sr_irq |-> $fell(ack_n));

  // R3
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_release |=> (ack_n && !sr_irq));

  // R9
  wait_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |=> $stable(ack_n));

  // R9
  disp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && !exec_done) |=> (disp_valid && $stable(disp_cmd)));

endmodule

bind hs_cmd_framer hsf_chk u_hsf_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ack_n      (ack_n),
  .sr_irq     (sr_irq),
  .disp_valid (disp_valid),
  .disp_cmd   (disp_cmd),
  .exec_done  (exec_done),
  .ev_strobe  (ev_strobe),
  .ev_release (ev_release)
);

// File: tb/hs_cmd_framer_bench.sv
module hs_cmd_framer_bench;

  localparam int DEPTH = 32;
  localparam int AW    = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          host_req_n = 1'b1;
  logic          ack_n;
  logic          host_wr = 1'b1;
  logic [7:0]    sr_in = 8'h00;
  logic [7:0]    sr_out;
  logic          sr_irq;
  logic          disp_valid;
  logic [7:0]    disp_cmd, disp_argc;
  logic [AW-1:0] arg_rd_idx = '0;
  logic [7:0]    arg_rd_data;
  logic          exec_done = 1'b0;
  logic [7:0]    exec_rsp_len = 8'd0;
  logic          rsp_wr_en = 1'b0;
  logic [AW-1:0] rsp_wr_idx = '0;
  logic [7:0]    rsp_wr_data = 8'h00;

  hs_cmd_framer #(.BUF_DEPTH(DEPTH)) u_hs_cmd_framer (
    .clk(clk), .rst_n(rst_n), .host_req_n(host_req_n), .ack_n(ack_n),
    .host_wr(host_wr), .sr_in(sr_in), .sr_out(sr_out), .sr_irq(sr_irq),
    .disp_valid(disp_valid), .disp_cmd(disp_cmd), .disp_argc(disp_argc),
    .arg_rd_idx(arg_rd_idx), .arg_rd_data(arg_rd_data),
    .exec_done(exec_done), .exec_rsp_len(exec_rsp_len),
    .rsp_wr_en(rsp_wr_en), .rsp_wr_idx(rsp_wr_idx), .rsp_wr_data(rsp_wr_data)
  );

  always #10 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  int exec_cnt = 0;
  bit finished = 0;

  logic [7:0] tx_args [64];
  logic [7:0] rsp_bytes [DEPTH];
  int         rsp_n = 0;
  logic [7:0] exp_cmd = 8'h00;
  int         exp_argc = 0;

  task automatic chk_eq(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Command shape as stated in R5 and R12
  function automatic void bshape(input int c, output bit kn, output bit av, output int al,
                                 output bit rv, output int rl);
    kn = 1; av = 0; al = 0; rv = 0; rl = 0;
    case (c)
      'h10: rl = 1;
      'h20: al = 1;
      'h21: begin av = 1; rv = 1; end
      'h30: al = 4;
      'h38: rl = 4;
      'h40: begin av = 1; rl = 2; end
      'h50: begin al = 2; rv = 1; end
      default: begin kn = 0; rv = (c < 128); rl = (c >= 128) ? 3 : 0; end
    endcase
  endfunction

  // One host strobe: drop request, wait acknowledge, read, release
  task automatic strobe(input bit wr, input logic [7:0] d, input bit exp_irq,
                        input string tag, output logic [7:0] got);
    @(negedge clk);
    host_wr = wr; sr_in = d; host_req_n = 1'b0;
    for (int k = 0; k < 400 && ack_n !== 1'b0; k++) @(negedge clk);
    chk_eq({tag, " R2 ack low"}, int'(ack_n), 0);
    chk_eq({tag, " R2 irq"}, int'(sr_irq), int'(exp_irq));
    got = sr_out;
    host_req_n = 1'b1;
    for (int k = 0; k < 400 && ack_n !== 1'b1; k++) @(negedge clk);
    chk_eq({tag, " R3 ack high"}, int'(ack_n), 1);
    chk_eq({tag, " R3 no irq on release"}, int'(sr_irq), 0);
  endtask

  // Executor model
  initial begin
    forever begin
      @(negedge clk);
      if (disp_valid === 1'b1) begin
        chk_eq("R9 disp_cmd", int'(disp_cmd), int'(exp_cmd));
        chk_eq("R9 disp_argc", int'(disp_argc), exp_argc);
        for (int i = 0; i < exp_argc && i < DEPTH; i++) begin
          arg_rd_idx = AW'(i);
          @(negedge clk);
          chk_eq("R7 stored arg", int'(arg_rd_data), int'(tx_args[i]));
        end
        for (int i = 0; i < rsp_n; i++) begin
          rsp_wr_en = 1'b1; rsp_wr_idx = AW'(i); rsp_wr_data = rsp_bytes[i];
          @(negedge clk);
          chk_eq("R9 dispatch held", int'(disp_valid), 1);
        end
        rsp_wr_en = 1'b0;
        exec_done = 1'b1; exec_rsp_len = 8'(rsp_n);
        @(negedge clk);
        exec_done = 1'b0;
        exec_cnt++;
      end
    end
  end

  // Full transaction; inj_arg / inj_rsp place a wrong-direction strobe (R8)
  task automatic txn(input logic [7:0] c, input int n_var, input int var_sz,
                     input int inj_arg, input int inj_rsp);
    bit kn, av, rv; int al, rl, cnt, n, e0; logic [7:0] g;
    string t;
    bshape(int'(c), kn, av, al, rv, rl);
    cnt = av ? n_var : al;
    for (int i = 0; i < cnt && i < 64; i++) tx_args[i] = 8'($urandom);
    for (int i = 0; i < DEPTH; i++) rsp_bytes[i] = 8'($urandom);
    rsp_n = rv ? var_sz : rl;
    exp_cmd = c; exp_argc = cnt;
    e0 = exec_cnt;
    strobe(1'b1, c, 1'b1, "R5 command", g);
    if (av) strobe(1'b1, 8'(cnt), 1'b1, "R6 length byte", g);
    for (int i = 0; i < cnt; i++) begin
      if (i == inj_arg) strobe(1'b0, 8'hA5, 1'b0, "R8 read in arg phase", g);
      strobe(1'b1, tx_args[i], 1'b1, "R7 arg", g);
    end
    chk_eq(kn ? "R9 dispatched once" : "R12 not dispatched", exec_cnt - e0, kn ? 1 : 0);
    n = rl;
    t = kn ? (rv ? "R11" : "R10") : "R12";
    if (rv) begin
      strobe(1'b0, 8'h00, 1'b1, {t, " size"}, g);
      n = kn ? rsp_n : 0;
      chk_eq({t, " size byte"}, int'(g), n);
    end
    for (int i = 0; i < n; i++) begin
      if (i == inj_rsp) strobe(1'b1, 8'h5A, 1'b0, "R8 write in rsp phase", g);
      strobe(1'b0, 8'h00, 1'b1, {t, " rsp"}, g);
      chk_eq({t, " rsp byte"}, int'(g), kn ? int'(rsp_bytes[i]) : 0);
    end
  endtask

  logic [7:0] kcodes [7] = '{8'h10, 8'h20, 8'h21, 8'h30, 8'h38, 8'h40, 8'h50};

  initial begin
    logic [7:0] g;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    // R1
    chk_eq("R1 ack_n", int'(ack_n), 1);
    chk_eq("R1 sr_irq", int'(sr_irq), 0);
    chk_eq("R1 disp_valid", int'(disp_valid), 0);
    rst_n = 1'b1;
    // R4: request held high, other inputs wiggle
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); sr_in = 8'(i * 37); host_wr = i[0];
      chk_eq("R4 idle ack", int'(ack_n), 1);
      chk_eq("R4 idle irq", int'(sr_irq), 0);
    end
    // R8 in idle: read strobe must not start a command
    strobe(1'b0, 8'h10, 1'b0, "R8 read in idle", g);
    txn(8'h38, 0, 0, -1, -1);            // R10 fixed response of 4
    txn(8'h30, 0, 0, 2, -1);             // R8 mismatch inside args
    txn(8'h38, 0, 0, -1, 1);             // R8 mismatch inside response
    txn(8'h20, 0, 0, -1, -1);            // R13
    txn(8'h10, 0, 0, -1, -1);
    txn(8'h21, 40, 5, -1, -1);           // R7 overflow, R11
    txn(8'h40, 0, 0, -1, -1);            // R6 zero in-band count
    txn(8'h50, 0, 0, -1, -1);            // R11 size zero
    txn(8'h85, 0, 0, -1, -1);            // R12 fixed zeros
    txn(8'h05, 0, 0, -1, -1);            // R12 in-band zero size
    for (int r = 0; r < 40; r++) begin
      logic [7:0] c;
      c = ($urandom % 4 == 0) ? 8'($urandom) : kcodes[$urandom % 7];
      txn(c, int'($urandom % 41), int'($urandom % 9),
          ($urandom % 5 == 0) ? int'($urandom % 3) : -1,
          ($urandom % 5 == 0) ? int'($urandom % 2) : -1);
    end
    @(negedge clk);
    chk_eq("R1 back to idle", int'(disp_valid), 0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule